// File: doc/BRIEF.md
# Dual-Width Staged Data Memory

This block is a data store organised as 256-bit rows, each holding eight 32-bit words. A narrow port reads or writes a single word, and a wide port reads or writes a complete row. Both ports take byte addresses. Every word has its own validity flag. A read that touches a word whose flag is clear reports an error and returns no data.

Writes do not reach the array at once. An accepted store is first held in a recorded slot. A commit strobe moves the recorded store into a pending slot and, in the same edge, writes the previous pending contents into the array. Reads look through the pending slot, so a value that is still waiting to land is already visible. An abort strobe throws away the recorded store before it can become pending. An invalidate input clears the validity of everything already in the array, but it does not touch the pending slot. That slot's writes still land later and are valid.

The narrow read results are combinational on the current address. All state changes on the rising clock edge.

Top module: `dual_dmem`

## Requirements
- R1: After reset every word is invalid and the pending slot is empty, so any legal read reports an error.
- R2: Byte address A selects row A/32 and word A[4:2] within that row. Word i of a row occupies bits [32i+31:32i] of the wide data.
- R3: A narrow access with A[1:0] nonzero, or a wide access with A[4:0] nonzero, or any access with A at or beyond ROWS*32, raises that port's alignment error in the same cycle. The access is then ignored, and such a store changes no word.
- R4: A legal read of an invalid word raises the read error and returns zero. A wide read fails as a whole, with zero data, if any of its eight words is invalid.
- R5: A store is recorded at the clock edge and is not visible to reads. The next commit makes it pending. The commit after that writes it into the array, and the written words become valid.
- R6: A store presented in the same cycle as a commit goes straight into the pending slot.
- R7: Reads return pending data in place of array data, and a pending word counts as valid.
- R8: A wide store writes all eight words of its row.
- R9: An abort discards the recorded store, including a store presented in the abort cycle, so it never lands.
- R10: Invalidate clears the validity of every word in the array. A write already in the pending slot survives and lands valid, even when the commit that lands it comes in the same cycle as the invalidate.
- R11: When both ports store in one cycle, only the wide store is recorded. A later store replaces an uncommitted recorded store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_req_i | input | 1 | Narrow access request |
| n_we_i | input | 1 | Narrow access is a store |
| n_addr_i | input | ADDR_W | Narrow byte address |
| n_wdata_i | input | 32 | Narrow store data |
| n_rdata_o | output | 32 | Narrow read data, zero unless the read is good |
| n_rerr_o | output | 1 | Narrow read hit an invalid word |
| n_aerr_o | output | 1 | Narrow address misaligned or out of range |
| w_req_i | input | 1 | Wide access request |
| w_we_i | input | 1 | Wide access is a store |
| w_addr_i | input | ADDR_W | Wide byte address |
| w_wdata_i | input | 256 | Wide store data |
| w_rdata_o | output | 256 | Wide read data, zero unless the read is good |
| w_rerr_o | output | 1 | Wide read covered an invalid word |
| w_aerr_o | output | 1 | Wide address misaligned or out of range |
| commit_i | input | 1 | Advance the store stages |
| abort_i | input | 1 | Discard the recorded store |
| invalidate_i | input | 1 | Clear validity of all array words |

## Verification
The scenarios cover several store patterns:
- a lone narrow store, read before each of its two commits;
- a wide store, read back through both ports;
- a narrow store and a wide store in the same cycle;
- two stores before a single commit.

Reading at each step shows whether data sits in the recorded slot, the pending slot or the array. A row holding just one valid word separates a wide read that checks all eight validity flags from one that checks only some. Two invalidate patterns are used: invalidate alone while a write is pending, and invalidate together with the landing commit. Together they show whether pending writes escape the clearing.

// File: rtl/dual_dmem_pkg.sv
package dual_dmem_pkg;
  localparam int WORD_W    = 32;
  localparam int ROW_WORDS = 8;
  localparam int ROW_BITS  = WORD_W * ROW_WORDS;
  localparam int ROW_IDX_W = 15;  // 32768 rows = 1 MiB ceiling

  typedef struct packed {
    logic                 vld;
    logic [ROW_IDX_W-1:0] row;
    logic [ROW_WORDS-1:0] mask;
    logic [ROW_BITS-1:0]  data;
  } stage_t;
endpackage

// File: rtl/dual_dmem_addr.sv
module dual_dmem_addr
  import dual_dmem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROWS   = 8,
  parameter bit WIDE   = 1'b0
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 ok_o,
  output logic [ROW_IDX_W-1:0] row_o,
  output logic [2:0]           word_o
);
  localparam logic [ADDR_W:0] SIZE_B = (ADDR_W+1)'(ROWS * 32);

  logic aligned;
  generate
    if (WIDE) begin : g_wide
      assign aligned = (addr_i[4:0] == 5'd0);
    end else begin : g_narrow
      assign aligned = (addr_i[1:0] == 2'd0);
    end
  endgenerate

  assign ok_o   = aligned && ({1'b0, addr_i} < SIZE_B);
  assign row_o  = ROW_IDX_W'(addr_i >> 5);
  assign word_o = addr_i[4:2];
endmodule

// File: rtl/dual_dmem_stage.sv
module dual_dmem_stage
  import dual_dmem_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  stage_t new_i,
  input  logic   commit_i,
  input  logic   abort_i,
  output stage_t rec_o,
  output stage_t pend_o
);
  stage_t rec_q, pend_q, rec_eff;

  // newest store replaces an uncommitted one
  assign rec_eff = new_i.vld ? new_i : rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q  <= '0;
      pend_q <= '0;
    end else begin
      if (abort_i || commit_i) rec_q <= '0;
      else                     rec_q <= rec_eff;
      if (commit_i) pend_q <= abort_i ? '0 : rec_eff;
    end
  end

  assign rec_o  = rec_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dual_dmem_array.sv
module dual_dmem_array
  import dual_dmem_pkg::*;
#(
  parameter int ROWS = 8,
  localparam int ROW_AW = $clog2(ROWS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  stage_t                    pend_i,
  input  logic                      land_i,
  input  logic                      invalidate_i,
  input  logic [ROW_IDX_W-1:0]      rd_row_i  [2],
  output logic [ROW_BITS-1:0]       rd_data_o [2],
  output logic [ROW_WORDS-1:0]      rd_vld_o  [2],
  output logic [ROWS*ROW_WORDS-1:0] valid_o
);
  logic [ROW_BITS-1:0]  mem_q [ROWS];
  logic [ROW_WORDS-1:0] vld_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = land_i && pend_i.vld && (pend_i.row == ROW_IDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[r] <= '0;
      else vld_q[r] <= (invalidate_i ? '0 : vld_q[r]) | (hit ? pend_i.mask : '0);
    end

    always_ff @(posedge clk_i) begin
      for (int i = 0; i < ROW_WORDS; i++) begin
        if (hit && pend_i.mask[i])
          mem_q[r][i*WORD_W +: WORD_W] <= pend_i.data[i*WORD_W +: WORD_W];
      end
    end

    assign valid_o[r*ROW_WORDS +: ROW_WORDS] = vld_q[r];
  end

  // read ports with forwarding from the pending slot
  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [ROW_AW-1:0] ridx;
    logic              fwd;
    assign ridx = rd_row_i[p][ROW_AW-1:0];
    assign fwd  = pend_i.vld && (pend_i.row == rd_row_i[p]);

    always_comb begin
      for (int i = 0; i < ROW_WORDS; i++) begin
        if (fwd && pend_i.mask[i]) begin
          rd_data_o[p][i*WORD_W +: WORD_W] = pend_i.data[i*WORD_W +: WORD_W];
          rd_vld_o[p][i] = 1'b1;
        end else begin
          rd_data_o[p][i*WORD_W +: WORD_W] = mem_q[ridx][i*WORD_W +: WORD_W];
          rd_vld_o[p][i] = vld_q[ridx][i];
        end
      end
    end
  end
endmodule

// File: rtl/dual_dmem.sv
module dual_dmem
  import dual_dmem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROWS   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              n_req_i,
  input  logic              n_we_i,
  input  logic [ADDR_W-1:0] n_addr_i,
  input  logic [31:0]       n_wdata_i,
  output logic [31:0]       n_rdata_o,
  output logic              n_rerr_o,
  output logic              n_aerr_o,
  input  logic              w_req_i,
  input  logic              w_we_i,
  input  logic [ADDR_W-1:0] w_addr_i,
  input  logic [255:0]      w_wdata_i,
  output logic [255:0]      w_rdata_o,
  output logic              w_rerr_o,
  output logic              w_aerr_o,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              invalidate_i
);
  logic                      n_ok, w_ok;
  logic [ROW_IDX_W-1:0]      n_row, w_row;
  logic [2:0]                n_word, w_word;
  stage_t                    new_s, rec_s, pend_s;
  logic [ROW_IDX_W-1:0]      rd_row  [2];
  logic [ROW_BITS-1:0]       rd_data [2];
  logic [ROW_WORDS-1:0]      rd_vld  [2];
  logic [ROWS*ROW_WORDS-1:0] valid_flat;

  dual_dmem_addr #(.ADDR_W(ADDR_W), .ROWS(ROWS), .WIDE(1'b0)) u_n_addr (
    .addr_i(n_addr_i), .ok_o(n_ok), .row_o(n_row), .word_o(n_word)
  );
  dual_dmem_addr #(.ADDR_W(ADDR_W), .ROWS(ROWS), .WIDE(1'b1)) u_w_addr (
    .addr_i(w_addr_i), .ok_o(w_ok), .row_o(w_row), .word_o(w_word)
  );

  assign n_aerr_o = n_req_i && !n_ok;
  assign w_aerr_o = w_req_i && !w_ok;

  // wide store wins over a simultaneous narrow store
  always_comb begin
    new_s = '0;
    if (w_req_i && w_we_i && w_ok) begin
      new_s.vld  = 1'b1;
      new_s.row  = w_row;
      new_s.mask = '1;
      new_s.data = w_wdata_i;
    end else if (n_req_i && n_we_i && n_ok) begin
      new_s.vld  = 1'b1;
      new_s.row  = n_row;
      new_s.mask = ROW_WORDS'(1) << n_word;
      new_s.data = ROW_BITS'(n_wdata_i) << {n_word, 5'd0};
    end
  end

  dual_dmem_stage u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_i(new_s), .commit_i(commit_i),
    .abort_i(abort_i), .rec_o(rec_s), .pend_o(pend_s)
  );

  assign rd_row[0] = n_row;
  assign rd_row[1] = w_row;

  dual_dmem_array #(.ROWS(ROWS)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_s), .land_i(commit_i),
    .invalidate_i(invalidate_i), .rd_row_i(rd_row), .rd_data_o(rd_data),
    .rd_vld_o(rd_vld), .valid_o(valid_flat)
  );

  logic n_rd, w_rd, n_good, w_good;
  assign n_rd   = n_req_i && !n_we_i && n_ok;
  assign w_rd   = w_req_i && !w_we_i && w_ok;
  assign n_good = rd_vld[0][n_word];
  assign w_good = &rd_vld[1];
  assign n_rerr_o  = n_rd && !n_good;
  assign w_rerr_o  = w_rd && !w_good;
  assign n_rdata_o = (n_rd && n_good) ? rd_data[0][{n_word, 5'd0} +: 32] : '0;
  assign w_rdata_o = (w_rd && w_good) ? rd_data[1] : '0;
endmodule

// File: rtl/dual_dmem_chk.sv
module dual_dmem_chk #(
  parameter int ROWS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              n_req_i,
  input logic              n_aerr_o,
  input logic              n_rerr_o,
  input logic              w_req_i,
  input logic              w_aerr_o,
  input logic              w_rerr_o,
  input logic [255:0]      w_rdata_o,
  input logic [31:0]       n_rdata_o,
  input logic              commit_i,
  input logic              abort_i,
  input logic              invalidate_i,
  input logic              rec_vld,
  input logic              pend_vld,
  input logic [ROWS*8-1:0] valid_flat
);
  assert_n_aerr_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_aerr_o |-> n_req_i);
  assert_w_aerr_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_aerr_o |-> w_req_i);
  assert_w_err_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_rerr_o |-> (w_rdata_o == '0));
  assert_n_err_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_rerr_o |-> (n_rdata_o == '0) && !n_aerr_o);
  assert_commit_pends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && rec_vld && !abort_i |=> pend_vld);
  assert_abort_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !rec_vld);
  assert_inval_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_i && !commit_i |=> (valid_flat == '0));
endmodule

bind dual_dmem dual_dmem_chk #(.ROWS(ROWS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .n_req_i(n_req_i), .n_aerr_o(n_aerr_o),
  .n_rerr_o(n_rerr_o), .w_req_i(w_req_i), .w_aerr_o(w_aerr_o),
  .w_rerr_o(w_rerr_o), .w_rdata_o(w_rdata_o), .n_rdata_o(n_rdata_o),
  .commit_i(commit_i), .abort_i(abort_i), .invalidate_i(invalidate_i),
  .rec_vld(rec_s.vld), .pend_vld(pend_s.vld), .valid_flat(valid_flat)
);

// File: tb/dual_dmem_tb_top.sv
module dual_dmem_tb_top;
  localparam int ADDR_W = 12;
  localparam int ROWS   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic n_req_i = 0, n_we_i = 0;
  logic [ADDR_W-1:0] n_addr_i = '0;
  logic [31:0] n_wdata_i = '0;
  logic [31:0] n_rdata_o;
  logic n_rerr_o, n_aerr_o;
  logic w_req_i = 0, w_we_i = 0;
  logic [ADDR_W-1:0] w_addr_i = '0;
  logic [255:0] w_wdata_i = '0;
  logic [255:0] w_rdata_o;
  logic w_rerr_o, w_aerr_o;
  logic commit_i = 0, abort_i = 0, invalidate_i = 0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_dmem #(.ADDR_W(ADDR_W), .ROWS(ROWS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .n_req_i(n_req_i), .n_we_i(n_we_i), .n_addr_i(n_addr_i), .n_wdata_i(n_wdata_i),
    .n_rdata_o(n_rdata_o), .n_rerr_o(n_rerr_o), .n_aerr_o(n_aerr_o),
    .w_req_i(w_req_i), .w_we_i(w_we_i), .w_addr_i(w_addr_i), .w_wdata_i(w_wdata_i),
    .w_rdata_o(w_rdata_o), .w_rerr_o(w_rerr_o), .w_aerr_o(w_aerr_o),
    .commit_i(commit_i), .abort_i(abort_i), .invalidate_i(invalidate_i)
  );

  function automatic logic [255:0] row_pat(input logic [15:0] tag);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = {tag, 16'(i)};
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic commit();
    commit_i = 1; step(); commit_i = 0;
  endtask

  task automatic nstore(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    n_req_i = 1; n_we_i = 1; n_addr_i = a; n_wdata_i = d;
    step();
    n_req_i = 0; n_we_i = 0;
  endtask

  task automatic wstore(input logic [ADDR_W-1:0] a, input logic [255:0] d);
    w_req_i = 1; w_we_i = 1; w_addr_i = a; w_wdata_i = d;
    step();
    w_req_i = 0; w_we_i = 0;
  endtask

  task automatic nread(input logic [ADDR_W-1:0] a, input bit eerr,
                       input logic [31:0] edata, input string req);
    n_req_i = 1; n_we_i = 0; n_addr_i = a;
    #1;
    check(n_rerr_o == eerr && n_aerr_o == 1'b0, {req, " nerr"}, 256'(n_rerr_o), 256'(eerr));
    check(n_rdata_o == edata, {req, " ndata"}, 256'(n_rdata_o), 256'(edata));
    n_req_i = 0;
  endtask

  task automatic wread(input logic [ADDR_W-1:0] a, input bit eerr,
                       input logic [255:0] edata, input string req);
    w_req_i = 1; w_we_i = 0; w_addr_i = a;
    #1;
    check(w_rerr_o == eerr && w_aerr_o == 1'b0, {req, " werr"}, 256'(w_rerr_o), 256'(eerr));
    check(w_rdata_o == edata, {req, " wdata"}, w_rdata_o, edata);
    w_req_i = 0;
  endtask

  task automatic t_reset();  // R1
    nread(12'h000, 1, 0, "R1");
    wread(12'h0E0, 1, 0, "R1");
  endtask

  task automatic t_staged();  // R5 R7
    nstore(12'h024, 32'h1234_5678);
    nread(12'h024, 1, 0, "R5 recorded");
    commit();
    nread(12'h024, 0, 32'h1234_5678, "R7 pending");
    commit();
    nread(12'h024, 0, 32'h1234_5678, "R5 landed");
    commit();
    nread(12'h024, 0, 32'h1234_5678, "R5 idle commit");
  endtask

  task automatic t_wide();  // R8 R2
    wstore(12'h040, row_pat(16'hC0DE));
    commit(); commit();
    wread(12'h040, 0, row_pat(16'hC0DE), "R8");
    nread(12'h04C, 0, 32'hC0DE_0003, "R2 word3");
    nread(12'h05C, 0, 32'hC0DE_0007, "R2 word7");
  endtask

  task automatic t_partial();  // R4
    wread(12'h020, 1, 0, "R4 partial row");
    nread(12'h020, 1, 0, "R4 narrow invalid");
  endtask

  task automatic t_align();  // R3
    n_req_i = 1; n_addr_i = 12'h022; #1;
    check(n_aerr_o == 1 && n_rerr_o == 0, "R3 narrow misaligned", 256'(n_aerr_o), 1);
    n_addr_i = 12'h100; #1;
    check(n_aerr_o == 1, "R3 narrow range", 256'(n_aerr_o), 1);
    n_addr_i = 12'h0FC; #1;
    check(n_aerr_o == 0, "R3 narrow last word", 256'(n_aerr_o), 0);
    n_req_i = 0;
    w_req_i = 1; w_addr_i = 12'h044; #1;
    check(w_aerr_o == 1, "R3 wide misaligned", 256'(w_aerr_o), 1);
    w_addr_i = 12'h100; #1;
    check(w_aerr_o == 1, "R3 wide range", 256'(w_aerr_o), 1);
    w_addr_i = 12'h0E0; #1;
    check(w_aerr_o == 0, "R3 wide last row", 256'(w_aerr_o), 0);
    w_req_i = 0;
    nstore(12'h022, 32'hDEAD_BEEF);
    wstore(12'h064, row_pat(16'hBAD0));
    commit(); commit();
    nread(12'h020, 1, 0, "R3 ignored narrow store");
    wread(12'h060, 1, 0, "R3 ignored wide store");
  endtask

  task automatic t_abort();  // R9
    nstore(12'h060, 32'hAAAA_0001);
    abort_i = 1; step(); abort_i = 0;
    commit(); commit();
    nread(12'h060, 1, 0, "R9 abort later");
    n_req_i = 1; n_we_i = 1; n_addr_i = 12'h064; n_wdata_i = 32'hAAAA_0002;
    abort_i = 1; step(); abort_i = 0; n_req_i = 0; n_we_i = 0;
    commit(); commit();
    nread(12'h064, 1, 0, "R9 abort same cycle");
  endtask

  task automatic t_same();  // R6
    n_req_i = 1; n_we_i = 1; n_addr_i = 12'h068; n_wdata_i = 32'h6666_0068;
    commit_i = 1; step(); commit_i = 0; n_req_i = 0; n_we_i = 0;
    nread(12'h068, 0, 32'h6666_0068, "R6 direct to pending");
    commit();
    nread(12'h068, 0, 32'h6666_0068, "R6 landed");
  endtask

  task automatic t_priority();  // R11
    n_req_i = 1; n_we_i = 1; n_addr_i = 12'h0A0; n_wdata_i = 32'h1111_00A0;
    w_req_i = 1; w_we_i = 1; w_addr_i = 12'h0C0; w_wdata_i = row_pat(16'h00C0);
    step();
    n_req_i = 0; n_we_i = 0; w_req_i = 0; w_we_i = 0;
    commit(); commit();
    wread(12'h0C0, 0, row_pat(16'h00C0), "R11 wide wins");
    nread(12'h0A0, 1, 0, "R11 narrow dropped");
    nstore(12'h0E0, 32'hE0E0_0001);
    nstore(12'h0E4, 32'hE4E4_0002);
    commit(); commit();
    nread(12'h0E0, 1, 0, "R11 replaced store");
    nread(12'h0E4, 0, 32'hE4E4_0002, "R11 newest store");
  endtask

  task automatic t_inval();  // R10
    nstore(12'h080, 32'h8080_0001);
    commit();
    invalidate_i = 1; step(); invalidate_i = 0;
    nread(12'h024, 1, 0, "R10 cleared narrow");
    wread(12'h040, 1, 0, "R10 cleared row");
    nread(12'h080, 0, 32'h8080_0001, "R10 pending kept");
    commit();
    nread(12'h080, 0, 32'h8080_0001, "R10 pending landed");
    nstore(12'h084, 32'h8484_0002);
    commit();
    invalidate_i = 1; commit_i = 1; step(); invalidate_i = 0; commit_i = 0;
    nread(12'h084, 0, 32'h8484_0002, "R10 land with invalidate");
    nread(12'h080, 1, 0, "R10 older word cleared");
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_staged();
    t_wide();
    t_partial();
    t_align();
    t_abort();
    t_same();
    t_priority();
    t_inval();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule